// File: doc/BRIEF.md
# Cell Characterization Shift-Register Harness

The harness puts a small three-input, one-output logic cell between two shift registers so the cell can be exercised and observed through a handful of slow pins. A twelve-entry stimulus buffer of 3-bit vectors feeds the cell from its oldest stage. A 44-bit result buffer collects the cell output and presents its last bit on a serial pin. Several copies of the lane (stimulus buffer, cell, result buffer) sit side by side. They share one set of control logic: input synchronisers, a programmable clock divider and a trigger delay chain.

A mode pin selects between two behaviours. In stepping mode, each rising trigger shifts a new vector into the stimulus buffer and shifts the cell output into the result buffer. This serves for preloading stimuli, for piping vectors end to end and for reading results out. In burst mode, the trigger opens a gate on the divided fast clock. The stimulus buffer then rotates at the divided rate, replaying the preloaded vectors. A delay chain clocked at the full fast rate tells each result bit in turn when to sample the cell. All logic runs on the fast clock. Trigger and mode are treated as asynchronous pins.

Top module: `cth_harness`

## Requirements
- R1: In stepping mode, each synchronised rising trigger shifts the 3-bit pin vector into stage 0 of a 12-stage stimulus buffer. The cell always reads stage 11, the oldest stage.
- R2: In stepping mode, the result for the vector pushed on step k appears on the serial output after step k+55. After reset and before step 56, the serial output reads 0, because a zero vector gives majority 0.
- R3: In stepping mode, each step moves the result buffer one place toward the serial output, which shows bit 43. Reading a buffer therefore yields bit 43 first and bit 0 last.
- R4: The divider emits one tick every 2^(n+1) fast cycles while the gate (effective mode high and synchronised trigger high) is open, where n is the 3-bit setting. Setting 0 ticks on every second cycle. The divider count returns to zero whenever the gate is closed.
- R5: In burst mode, each divider tick rotates the stimulus buffer so that stage 11 refills stage 0. The cell therefore sees the preloaded vectors oldest first, wrapping after twelve.
- R6: In burst mode, result bit k samples the cell output on the (k+2)-th fast edge after the synchronised trigger rises, once per rising trigger. The result buffer does not shift in this mode.
- R7: Mode and trigger each pass through two synchronising flops. A new mode value takes effect only while the synchronised trigger is low; a mode pulse that begins and ends while the trigger is high has no effect.
- R8: The active-low reset clears both buffers, the divider count, the delay chain and the synchronisers.
- R9: All lanes share the control logic. A lane's cell is either a combinational 3-input majority or a majority registered on the fast clock, and the registered kind samples the input one fast cycle later in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; drives every register |
| rst_n | input | 1 | Asynchronous active-low reset |
| stim_in | input | 3 | Stimulus vector pushed on a stepping-mode trigger |
| mode_in | input | 1 | 0 = stepping mode, 1 = burst mode (asynchronous) |
| trig_in | input | 1 | Trigger (asynchronous) |
| div_sel | input | 3 | Divider setting n, period 2^(n+1) fast cycles |
| serial_out | output | N_LANES | Last result bit of each lane |

## Verification
The assertions assume that mode only changes while the trigger is low, and that the trigger holds each level for several fast cycles so the synchronised edge is clean. They also assume that a burst holds the trigger high for at least the chain length. The stimulus follows these rules. It drives pins on the falling clock, holds every trigger level for several cycles, and keeps burst triggers high for seventy cycles. The one deliberate exception is a mode pulse placed entirely inside a high trigger, which checks that such a pulse is ignored.

// File: rtl/cth_pkg.sv
package cth_pkg;
  // Divider period in fast cycles for setting n.
  function automatic int unsigned div_period(input int unsigned n);
    return 32'd1 << (n + 1);
  endfunction

  // Majority of three bits.
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction
endpackage

// File: rtl/cth_sync.sv
module cth_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cth_divider.sv
module cth_divider #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'(cth_pkg::div_period(32'(sel)) - 32'd1);
    tick = gate && (cnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!gate)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r4_closed_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> cnt == '0);
  a_r4_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == '0);
  a_r4_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !tick) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/cth_delay_chain.sv
module cth_delay_chain #(
  parameter int TAPS = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  output logic [TAPS-1:0] cap_en
);
  logic [TAPS:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[TAPS-1:0], trig};
  end

  // A tap fires on the cycle its stage has just risen.
  always_comb cap_en = chain[TAPS-1:0] & ~chain[TAPS:1];

  for (genvar k = 0; k < TAPS - 1; k++) begin : g_walk
    a_r6_edge_walks: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en[k] |=> cap_en[k+1]);
  end
endmodule

// File: rtl/cth_lane.sv
module cth_lane #(
  parameter int DEPTH   = 12,
  parameter int VW      = 3,
  parameter int OUT_LEN = 44,
  parameter bit SEQ     = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VW-1:0]      stim,
  input  logic               slow_step,
  input  logic               fast_tick,
  input  logic               fast_mode,
  input  logic [OUT_LEN-1:0] cap_en,
  output logic               serial_out
);
  logic [DEPTH-1:0][VW-1:0] stg;
  logic [OUT_LEN-1:0]       res;
  logic                     cell_y;
  logic [VW-1:0]            cell_in;

  always_comb cell_in = stg[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stg <= '0;
    else if (slow_step) stg <= {stg[DEPTH-2:0], stim};
    else if (fast_tick) stg <= {stg[DEPTH-2:0], stg[DEPTH-1]};
  end

  if (SEQ) begin : g_seq_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_y <= 1'b0;
      else        cell_y <= cth_pkg::maj3(cell_in[2:0]);
    end
  end else begin : g_comb_cell
    always_comb cell_y = cth_pkg::maj3(cell_in[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res <= '0;
    else if (slow_step) res <= {res[OUT_LEN-2:0], cell_y};
    else if (fast_mode) begin
      for (int k = 0; k < OUT_LEN; k++)
        if (cap_en[k]) res[k] <= cell_y;
    end
  end

  always_comb serial_out = res[OUT_LEN-1];

  a_r1_push: assert property (@(posedge clk) disable iff (!rst_n)
    slow_step |=> stg[0] == $past(stim));
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    slow_step |=> res[OUT_LEN-1:1] == $past(res[OUT_LEN-2:0]));
  a_r5_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_tick && !slow_step) |=> stg[0] == $past(stg[DEPTH-1]));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_tick && !slow_step) |=> $stable(stg));
endmodule

// File: rtl/cth_harness.sv
module cth_harness #(
  parameter int               N_LANES  = 8,
  parameter int               DEPTH    = 12,
  parameter int               OUT_LEN  = 44,
  parameter int               SEL_W    = 3,
  parameter logic [N_LANES-1:0] SEQ_MASK = 8'hAA
) (
  input  logic               clk_fast,
  input  logic               rst_n,
  input  logic [2:0]         stim_in,
  input  logic               mode_in,
  input  logic               trig_in,
  input  logic [SEL_W-1:0]   div_sel,
  output logic [N_LANES-1:0] serial_out
);
  localparam int VW = 3;

  logic [1:0]         sync_q;
  logic               mode_s, trig_s, trig_q, mode_eff;
  logic               slow_step, gate, tick;
  logic [OUT_LEN-1:0] cap_en;

  cth_sync #(.W(2)) u_sync (
    .clk(clk_fast), .rst_n(rst_n), .d({mode_in, trig_in}), .q(sync_q)
  );
  assign mode_s = sync_q[1];
  assign trig_s = sync_q[0];

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      mode_eff <= 1'b0;
    end else begin
      trig_q <= trig_s;
      if (!trig_s) mode_eff <= mode_s;
    end
  end

  always_comb begin
    slow_step = trig_s & ~trig_q & ~mode_eff;
    gate      = trig_s & mode_eff;
  end

  cth_divider #(.SEL_W(SEL_W)) u_div (
    .clk(clk_fast), .rst_n(rst_n), .gate(gate), .sel(div_sel), .tick(tick)
  );

  cth_delay_chain #(.TAPS(OUT_LEN)) u_chain (
    .clk(clk_fast), .rst_n(rst_n), .trig(trig_s), .cap_en(cap_en)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    cth_lane #(
      .DEPTH(DEPTH), .VW(VW), .OUT_LEN(OUT_LEN), .SEQ(SEQ_MASK[i])
    ) u_lane (
      .clk(clk_fast), .rst_n(rst_n), .stim(stim_in),
      .slow_step(slow_step), .fast_tick(tick), .fast_mode(mode_eff),
      .cap_en(cap_en), .serial_out(serial_out[i])
    );
  end

  a_r7_mode_when_idle: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(mode_eff) |-> !$past(trig_s));
  a_r4_no_tick_stepping: assert property (@(posedge clk_fast) disable iff (!rst_n)
    slow_step |-> !tick);
endmodule

// File: tb/tb_cth_harness.sv
module tb_cth_harness;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stim = '0;
  logic       mode = 1'b0;
  logic       trig = 1'b0;
  logic [2:0] div_sel = '0;
  logic [7:0] ser;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [2:0] hist [1:80];
  logic [2:0] vp   [1:12];
  logic       ec   [0:43];
  logic       es   [0:43];

  always #(CLK_P/2) clk = ~clk;

  cth_harness dut (
    .clk_fast(clk), .rst_n(rst_n), .stim_in(stim), .mode_in(mode),
    .trig_in(trig), .div_sel(div_sel), .serial_out(ser)
  );

  function automatic logic maj(input logic [2:0] v);
    return (int'(v[0]) + int'(v[1]) + int'(v[2])) >= 2;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] v);
    @(negedge clk); stim = v; trig = 1'b1;
    repeat (4) @(negedge clk);
    trig = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic burst(input int sel, input int seed);
    int p;
    p = 1 << (sel + 1);
    div_sel = 3'(sel);
    for (int i = 1; i <= 12; i++) begin
      vp[i] = 3'((i * 3 + seed) % 8);
      step(vp[i]);
    end
    for (int k = 0; k < 44; k++) begin
      ec[k] = maj(vp[((k + 1) / p) % 12 + 1]);
      es[k] = maj(vp[(k / p) % 12 + 1]);
    end
    @(negedge clk); mode = 1'b1;
    repeat (6) @(negedge clk);
    trig = 1'b1;
    repeat (70) @(negedge clk);
    trig = 1'b0;
    repeat (6) @(negedge clk);
    mode = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 44; i++) begin
      chk("R3 R4 R5 R6 comb readout", ser[0], ec[43 - i]);
      chk("R9 registered readout", ser[1], es[43 - i]);
      chk("R9 shared control", ser[2], ser[0]);
      step(3'd0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset clears all lanes", ser == 8'h00, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle after release", ser == 8'h00, 1'b1);

    // Stepping pipeline, with a mode pulse hidden inside step 30 (R7).
    for (int t = 1; t <= 70; t++) begin
      logic exp;
      hist[t] = 3'((t * 5 + 3) % 8);
      if (t == 30) begin
        @(negedge clk); stim = hist[t]; trig = 1'b1;
        repeat (2) @(negedge clk);
        mode = 1'b1;
        repeat (6) @(negedge clk);
        mode = 1'b0;
        repeat (4) @(negedge clk);
        trig = 1'b0;
        repeat (6) @(negedge clk);
      end else begin
        step(hist[t]);
      end
      exp = (t >= 56) ? maj(hist[t - 55]) : 1'b0;
      chk("R1 R2 R7 pipeline comb", ser[0], exp);
      chk("R1 R2 pipeline registered", ser[1], exp);
    end

    burst(0, 1);
    burst(1, 4);
    burst(2, 6);
    burst(3, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule